// File: doc/BRIEF.md
# Programmable I/O Select Decoder

This block watches the external bus address and produces a single active-low output pin. When the pin is in its I/O-select role, it goes low for every external bus cycle whose address falls inside a window at the top of the 24-bit space. The window always begins at 0xFFF000. A two-bit size code picks one of four upper bounds. The same pin can instead carry the ordinary active-low address strobe. A select-enable bit decides which of the two signals appears on it.

The address compare is purely combinational. The pin is gated by a bus-cycle-active qualifier, so it stays low for the whole of a matching external cycle and idles high between cycles and during internal accesses. The enable bit and the size code come from a control register that lives elsewhere. The block samples them into its own configuration flops on every clock edge, which gives them a defined reset state: strobe pass-through, with the widest window.

Top module: `iosel_decoder`

## Requirements
- R1: While reset is asserted, the configuration is forced to enable=0 and size code 11, so the pin equals `as_n_in` whatever `sel_en` and `win_size` carry.
- R2: With the loaded enable at 0, the pin equals `as_n_in`, independent of address and `cyc_active`.
- R3: With the loaded enable at 1 and `cyc_active` low, the pin is high.
- R4: Size code 00 with enable 1 and an active cycle drives the pin low exactly for addresses 0xFFF000 through 0xFFF03F.
- R5: Size code 01 with enable 1 and an active cycle drives the pin low exactly for addresses 0xFFF000 through 0xFFF0FF.
- R6: Size code 10 with enable 1 and an active cycle drives the pin low exactly for addresses 0xFFF000 through 0xFFF3FF.
- R7: Size code 11 with enable 1 and an active cycle drives the pin low exactly for addresses 0xFFF000 through 0xFFF7FF.
- R8: Addresses below 0xFFF000 never drive the pin low while enable is 1, for any size code.
- R9: A new `sel_en` or `win_size` value takes effect at the first rising clock edge after it is applied. Until that edge, the previous configuration governs the pin.
- R10: During a matching access held over several clock cycles with a stable address, the pin stays low in every cycle and returns high once `cyc_active` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 24 | External bus address |
| cyc_active | input | 1 | High while an external bus cycle is in progress |
| as_n_in | input | 1 | Active-low address strobe from the bus controller |
| sel_en | input | 1 | 1 selects the I/O-select role for the pin, 0 passes the strobe |
| win_size | input | 2 | Window size code (00 smallest .. 11 largest) |
| pin_n | output | 1 | Shared active-low output pin |

## Verification
The embedded properties check several rules on every cycle for every address: the pin is high when no cycle is active, addresses below the base or beyond the largest bound never select, the smallest window always selects, and reset forces the pass-through configuration. The exact edge of each of the four windows can only be shown by the bench scenarios. These scenarios probe one address under the base, the base itself, the bound and one past the bound for every size code. The one-cycle configuration latency, the pass-through role and the strobe held over a stretched cycle are also shown only by those scenarios.

// File: rtl/iosel_pkg.sv
// Package: shared types and the window-size table for the I/O select decoder.
// Assumes window sizes are powers of two and the base is aligned to the largest one.
package iosel_pkg;

    typedef enum logic [1:0] {
        SPAN_64B  = 2'b00,
        SPAN_256B = 2'b01,
        SPAN_1KB  = 2'b10,
        SPAN_2KB  = 2'b11
    } span_code_e;

    localparam int NUM_SPANS = 4;

    // Returns log2 of the window length for a given size code index.
    function automatic int span_log2(input int idx);
        case (idx)
            0:       return 6;
            1:       return 8;
            2:       return 10;
            default: return 11;
        endcase
    endfunction

endpackage

// File: rtl/iosel_cfg_reg.sv
// Module: configuration flops for the select decoder.
// Samples the enable bit and size code every clock; synchronous active-low
// reset loads enable=0 and the widest window. Assumes inputs are synchronous to clk.
module iosel_cfg_reg
    import iosel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_in,
    input  logic [1:0] size_in,
    output logic       en_q,
    output span_code_e size_q
);

    // Capture configuration, reset to strobe pass-through and widest window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            size_q <= SPAN_2KB;
        end else begin
            en_q   <= en_in;
            size_q <= span_code_e'(size_in);
        end
    end

    // R1: a reset cycle leaves the pass-through configuration behind it.
    assert_reset_cfg_R1: assert property (@(posedge clk)
        !rst_n |=> (!en_q && size_q == SPAN_2KB));

endmodule

// File: rtl/iosel_window_cmp.sv
// Module: combinational window comparator.
// Builds one range check per size code with a generate loop and picks the one
// named by the loaded code. Assumes BASE is aligned to the largest window.
module iosel_window_cmp
    import iosel_pkg::*;
#(
    parameter int                ADDR_W = 24,
    parameter logic [ADDR_W-1:0] BASE   = 24'hFFF000
) (
    input  logic [ADDR_W-1:0] addr,
    input  span_code_e        size_code,
    output logic              hit
);

    logic [ADDR_W-1:0]    offset;
    logic                 at_or_above;
    logic [NUM_SPANS-1:0] hit_vec;

    // Distance from the base and the lower-bound test.
    always_comb begin
        offset      = addr - BASE;
        at_or_above = (addr >= BASE);
    end

    for (genvar i = 0; i < NUM_SPANS; i++) begin : g_span
        localparam logic [ADDR_W-1:0] LEN = ADDR_W'(1) << span_log2(i);
        // Upper-bound test for window i.
        always_comb hit_vec[i] = at_or_above && (offset < LEN);
    end

    // Select the comparator for the loaded size code.
    always_comb hit = hit_vec[size_code];

endmodule

// File: rtl/iosel_pin_mux.sv
// Module: output pin role selection and cycle gating.
// In select role the pin is low only while a bus cycle is active and the
// address hits; otherwise the incoming strobe is passed through unchanged.
module iosel_pin_mux (
    input  logic sel_role,
    input  logic cyc_active,
    input  logic hit,
    input  logic as_n_in,
    output logic pin_n
);

    // Drive the shared pin from the role chosen by the loaded enable bit.
    always_comb begin
        if (sel_role) pin_n = ~(cyc_active & hit);
        else          pin_n = as_n_in;
    end

endmodule

// File: rtl/iosel_decoder.sv
// Module: top of the programmable I/O select decoder.
// Registers the configuration, compares the address combinationally and drives
// the shared active-low pin. Assumes addr is valid while cyc_active is high.
module iosel_decoder
    import iosel_pkg::*;
#(
    parameter int                ADDR_W = 24,
    parameter logic [ADDR_W-1:0] BASE   = 24'hFFF000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cyc_active,
    input  logic              as_n_in,
    input  logic              sel_en,
    input  logic [1:0]        win_size,
    output logic              pin_n
);

    localparam logic [ADDR_W-1:0] MIN_END = BASE + ADDR_W'((1 << span_log2(0)) - 1);
    localparam logic [ADDR_W-1:0] MAX_END = BASE + ADDR_W'((1 << span_log2(NUM_SPANS-1)) - 1);

    logic       cfg_en;
    span_code_e cfg_size;
    logic       win_hit;

    iosel_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_in   (sel_en),
        .size_in (win_size),
        .en_q    (cfg_en),
        .size_q  (cfg_size)
    );

    iosel_window_cmp #(.ADDR_W(ADDR_W), .BASE(BASE)) u_cmp (
        .addr      (addr),
        .size_code (cfg_size),
        .hit       (win_hit)
    );

    iosel_pin_mux u_mux (
        .sel_role   (cfg_en),
        .cyc_active (cyc_active),
        .hit        (win_hit),
        .as_n_in    (as_n_in),
        .pin_n      (pin_n)
    );

    // R3: no active cycle means the select pin idles high.
    assert_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && !cyc_active) |-> pin_n);

    // R8: addresses under the base never select.
    assert_below_base_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && addr < BASE) |-> pin_n);

    // R7: nothing past the largest bound selects, whatever the code.
    assert_beyond_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && addr > MAX_END) |-> pin_n);

    // R4: the smallest window is selected under every size code.
    assert_min_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && cyc_active && addr >= BASE && addr <= MIN_END) |-> !pin_n);

endmodule

// File: tb/iosel_decoder_test.sv
`timescale 1ns/1ps
module iosel_decoder_test;

    typedef struct {
        logic        exp;
        logic [23:0] a;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] addr = 24'h0;
    logic        cyc_active = 1'b0;
    logic        as_n_in = 1'b1;
    logic        sel_en = 1'b0;
    logic [1:0]  win_size = 2'b00;
    logic        pin_n;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    logic  eff_en = 1'b0;
    logic [1:0] eff_size = 2'b11;
    bit    in_reset = 1'b1;
    bit    done = 1'b0;

    always #2 clk = ~clk;

    iosel_decoder uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cyc_active(cyc_active),
        .as_n_in(as_n_in), .sel_en(sel_en), .win_size(win_size), .pin_n(pin_n)
    );

    // Reference behaviour taken from the requirements.
    function automatic logic model(logic en, logic [1:0] sz, logic [23:0] a,
                                   logic cyc, logic asn);
        logic [23:0] hi;
        case (sz)
            2'b00:   hi = 24'hFFF03F;
            2'b01:   hi = 24'hFFF0FF;
            2'b10:   hi = 24'hFFF3FF;
            default: hi = 24'hFFF7FF;
        endcase
        if (!en) return asn;
        return !(cyc && a >= 24'hFFF000 && a <= hi);
    endfunction

    // Driver: one cycle of stimulus, expected value queued for the monitor.
    task automatic step(input logic en, input logic [1:0] sz, input logic [23:0] a,
                        input logic cyc, input logic asn, input string tag);
        item_t it;
        @(posedge clk); #1;
        sel_en = en; win_size = sz; addr = a; cyc_active = cyc; as_n_in = asn;
        it.exp = model(eff_en, eff_size, a, cyc, asn);
        it.a = a; it.tag = tag;
        q.push_back(it);
        if (!in_reset) begin
            eff_en = en; eff_size = sz;   // R9: loaded at the next edge
        end
    endtask

    // Monitor: compare the pin against queued expectations away from the edge.
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (pin_n !== it.exp) begin
                    errors++;
                    $display("FAIL %s addr=%h pin_n actual=%b expected=%b",
                             it.tag, it.a, pin_n, it.exp);
                end
            end
        end
    end

    function automatic string size_tag(int s);
        case (s)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            default: return "R7";
        endcase
    endfunction

    initial begin
        logic [23:0] hi;
        // R1: reset forces pass-through even with select requested.
        step(1, 2'b00, 24'hFFF000, 1, 1'b0, "R1");
        step(1, 2'b00, 24'hFFF000, 1, 1'b1, "R1");
        step(1, 2'b00, 24'hFFF010, 1, 1'b0, "R1");
        rst_n = 1'b1; in_reset = 1'b0;
        eff_en = sel_en; eff_size = win_size;

        // R2: pass-through role ignores address and cycle.
        step(0, 2'b11, 24'hFFF000, 1, 1'b1, "R2");
        step(0, 2'b11, 24'hFFF000, 1, 1'b1, "R2");
        step(0, 2'b11, 24'hFFF100, 1, 1'b0, "R2");
        step(0, 2'b11, 24'h000000, 0, 1'b0, "R2");
        step(0, 2'b11, 24'hFFF7FF, 0, 1'b1, "R2");

        // R4..R7 and R8: boundary sweep for every size code.
        for (int s = 0; s < 4; s++) begin
            case (s)
                0: hi = 24'hFFF03F;
                1: hi = 24'hFFF0FF;
                2: hi = 24'hFFF3FF;
                default: hi = 24'hFFF7FF;
            endcase
            step(1, 2'(s), 24'h000000, 0, 1'b1, size_tag(s));
            step(1, 2'(s), 24'hFFEFFF, 1, 1'b0, "R8");
            step(1, 2'(s), 24'hFFF000, 1, 1'b1, size_tag(s));
            step(1, 2'(s), hi,         1, 1'b1, size_tag(s));
            step(1, 2'(s), hi + 24'h1, 1, 1'b0, size_tag(s));
            step(1, 2'(s), 24'h000100, 1, 1'b0, "R8");
        end

        // R3: no active cycle keeps the pin high.
        step(1, 2'b11, 24'hFFF000, 0, 1'b0, "R3");
        step(1, 2'b11, 24'hFFF200, 0, 1'b0, "R3");

        // R9: new size code only governs after the next edge.
        step(1, 2'b11, 24'hFFF080, 1, 1'b1, "R9");
        step(1, 2'b00, 24'hFFF080, 1, 1'b1, "R9");
        step(1, 2'b00, 24'hFFF080, 1, 1'b1, "R9");
        step(0, 2'b00, 24'hFFF000, 1, 1'b1, "R9");
        step(0, 2'b00, 24'hFFF000, 1, 1'b1, "R9");
        step(1, 2'b00, 24'hFFF000, 1, 1'b1, "R9");

        // R10: stretched matching cycle holds the pin low, then releases.
        step(1, 2'b10, 24'hFFF200, 1, 1'b0, "R10");
        step(1, 2'b10, 24'hFFF200, 1, 1'b0, "R10");
        step(1, 2'b10, 24'hFFF200, 1, 1'b0, "R10");
        step(1, 2'b10, 24'hFFF200, 1, 1'b0, "R10");
        step(1, 2'b10, 24'hFFF200, 0, 1'b1, "R10");

        @(posedge clk); @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule